// File: doc/BRIEF.md
# Nibble ALU with Decimal Mode and Skip Evaluation

This block is the 4-bit datapath of a small controller core. The core loads the first operand into `opa` and the second into `opb`. It then raises `exec` for one cycle with an operation code and the current mode bits. In that same cycle the block returns the result nibble, a write strobe for the destination, and a request to skip the following instruction. The carry and zero flags live inside the block and change on the clock edge that ends the `exec` cycle.

Two mode inputs change how arithmetic behaves. `dec_mode` turns on decimal correction of sums and differences. `cmp_mode` turns arithmetic into a flag-only operation: the result is not written back, and a zero result leaves the zero flag as it was. A wide comparison can therefore be run one nibble at a time, and the zero flag ends up set only if every nibble matched. Conditional behaviour is expressed only through the skip request. No branch flags are produced.

Top module: `nibble_alu`

## Requirements
- R1: The operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 skip-if-mask-all-ones, 8 skip-if-mask-all-zeros, 9 skip-if-equal, 10 skip-if-not-equal, 11 skip-if-greater-or-equal, 12 skip-if-less, and 13 rotate-right-through-carry. After reset, carry and zero read 0.
- R2: With `dec_mode`=0, arithmetic is 4-bit binary. Codes 1 and 3 add the carry flag or subtract it as a borrow. The carry flag takes the carry-out of an addition, or 1 when a subtraction goes below zero. An add-with-carry of a nibble to itself rotates it left through carry.
- R3: With `dec_mode`=1, a sum above 9 has 6 added and sets carry, and a subtraction that borrows has 6 taken off and sets carry. The result is the low 4 bits.
- R4: `wr_en` is 1 during `exec` for arithmetic with `cmp_mode`=0, for logic operations and for rotate. It is 0 for arithmetic with `cmp_mode`=1 and for every skip operation.
- R5: After arithmetic, a nonzero result clears zero. A zero result sets zero when `cmp_mode`=0 and leaves zero unchanged when `cmp_mode`=1.
- R6: AND, OR and XOR return the bitwise result of `opa` and `opb` and leave carry and zero unchanged.
- R7: The mask tests use `opb` as the mask. Code 7 skips when every masked bit of `opa` is 1. Code 8 skips when every masked bit of `opa` is 0. Neither test changes the flags.
- R8: The compare skips evaluate `opa` against `opb` as unsigned values, with `opb` as the immediate. They leave carry and zero unchanged.
- R9: Rotate right returns {carry, `opa`[3:1]} and loads `opa`[0] into carry. Zero is unchanged.
- R10: `skip`, `result` and `wr_en` are valid in the `exec` cycle itself. When `exec`=0, `skip` and `wr_en` are 0 and the flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| exec | input | 1 | Execute strobe, one cycle per operation |
| opcode | input | 4 | Operation code (R1) |
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand, immediate or mask |
| dec_mode | input | 1 | Decimal arithmetic mode |
| cmp_mode | input | 1 | Compare mode: arithmetic affects flags only |
| result | output | 4 | Result nibble |
| wr_en | output | 1 | Destination write strobe |
| skip | output | 1 | Skip the next instruction |
| cy | output | 1 | Carry flag |
| zf | output | 1 | Zero flag |

## Verification
The hardest situation to reach is the zero flag held across a compare chain. Observing it needs a known zero flag, then a zero result with `cmp_mode`=1, then a nonzero one, then another zero. The stimulus first forces zero to 1 with a decimal add whose corrected result wraps to 0. It then runs a chain of compare-mode subtractions and checks zero after each one. This shows that zero survives a matching nibble and stays cleared once a mismatch has occurred. Carry-in cases are set up the same way: a preceding operation leaves carry in a known state before each add-with-carry, subtract-with-borrow or rotate.

// File: rtl/nibble_alu.sv
module nibble_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [3:0] opcode,
  input  logic [3:0] opa,
  input  logic [3:0] opb,
  input  logic       dec_mode,
  input  logic       cmp_mode,
  output logic [3:0] result,
  output logic       wr_en,
  output logic       skip,
  output logic       cy,
  output logic       zf
);

  localparam logic [3:0] OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBC = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6;
  localparam logic [3:0] OP_TONE = 4'd7,  OP_TZRO = 4'd8,  OP_EQ   = 4'd9,  OP_NE   = 4'd10;
  localparam logic [3:0] OP_GE   = 4'd11, OP_LT   = 4'd12, OP_ROR  = 4'd13;

  logic cy_q, z_q;
  logic is_arith, is_logic, is_cmp, is_ror;
  logic cin;
  logic [4:0] raw_add, raw_sub;
  logic [3:0] ar_res;
  logic       ar_c;
  logic       cond;
  logic       cy_d, z_d;

  assign is_arith = (opcode <= OP_SUBC);
  assign is_logic = (opcode == OP_AND) || (opcode == OP_OR) || (opcode == OP_XOR);
  assign is_cmp   = (opcode >= OP_EQ) && (opcode <= OP_LT);
  assign is_ror   = (opcode == OP_ROR);

  assign cin     = opcode[0] & cy_q;
  assign raw_add = {1'b0, opa} + {1'b0, opb} + {4'd0, cin};
  assign raw_sub = {1'b0, opa} - {1'b0, opb} - {4'd0, cin};

  always_comb begin
    if (!opcode[1]) begin
      if (dec_mode && raw_add > 5'd9) begin
        ar_res = raw_add[3:0] + 4'd6;
        ar_c   = 1'b1;
      end else begin
        ar_res = raw_add[3:0];
        ar_c   = raw_add[4];
      end
    end else begin
      ar_c   = raw_sub[4];
      ar_res = (dec_mode && raw_sub[4]) ? raw_sub[3:0] - 4'd6 : raw_sub[3:0];
    end
  end

  always_comb begin
    result = 4'd0;
    cond   = 1'b0;
    unique case (opcode)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: result = ar_res;
      OP_AND:  result = opa & opb;
      OP_OR:   result = opa | opb;
      OP_XOR:  result = opa ^ opb;
      OP_TONE: cond = ((opa & opb) == opb);
      OP_TZRO: cond = ((opa & opb) == 4'd0);
      OP_EQ:   cond = (opa == opb);
      OP_NE:   cond = (opa != opb);
      OP_GE:   cond = (opa >= opb);
      OP_LT:   cond = (opa < opb);
      OP_ROR:  result = {cy_q, opa[3:1]};
      default: ;
    endcase
  end

  assign wr_en = exec && ((is_arith && !cmp_mode) || is_logic || is_ror);
  assign skip  = exec && cond;

  always_comb begin
    cy_d = cy_q;
    z_d  = z_q;
    if (exec && is_arith) begin
      cy_d = ar_c;
      if (ar_res != 4'd0) z_d = 1'b0;
      else if (!cmp_mode) z_d = 1'b1;
    end else if (exec && is_ror) begin
      cy_d = opa[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q <= 1'b0;
      z_q  <= 1'b0;
    end else begin
      cy_q <= cy_d;
      z_q  <= z_d;
    end
  end

  assign cy = cy_q;
  assign zf = z_q;

  a_r8_cmp_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    exec && is_cmp |=> $stable(cy) && $stable(zf));
  a_r6_logic_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    exec && is_logic |=> $stable(cy) && $stable(zf));
  a_r5_cmp_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    exec && is_arith && cmp_mode && result == 4'd0 |=> $stable(zf));
  a_r5_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    exec && is_arith && result != 4'd0 |=> !zf);
  a_r9_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
    exec && is_ror |=> cy == $past(opa[0]));
  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    exec && is_arith && cmp_mode |-> !wr_en);
  a_r10_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(cy) && $stable(zf));

endmodule

// File: tb/nibble_alu_tb.sv
module nibble_alu_tb;
  logic clk = 0, rst_n = 0, exec = 0, dec_mode = 0, cmp_mode = 0;
  logic [3:0] opcode = 0, opa = 0, opb = 0;
  logic [3:0] result;
  logic wr_en, skip, cy, zf;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  nibble_alu u_dut (.clk(clk), .rst_n(rst_n), .exec(exec), .opcode(opcode), .opa(opa), .opb(opb),
    .dec_mode(dec_mode), .cmp_mode(cmp_mode), .result(result), .wr_en(wr_en), .skip(skip),
    .cy(cy), .zf(zf));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b,
                     input logic dm, input logic cm, input logic [3:0] er, input logic ew,
                     input logic es, input logic ec, input logic ez, input string tag);
    @(negedge clk);
    opcode = op; opa = a; opb = b; dec_mode = dm; cmp_mode = cm; exec = 1;
    #1;
    if (ew || op <= 4'd6 || op == 4'd13) chk(tag, "result", result, er);
    chk(tag, "wr_en", wr_en, ew);
    chk(tag, "skip", skip, es);
    @(posedge clk); #1;
    exec = 0;
    chk(tag, "cy", cy, ec);
    chk(tag, "zf", zf, ez);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "cy", cy, 0);
    chk("R1", "zf", zf, 0);
    chk("R10", "skip", skip, 0);
    chk("R10", "wr_en", wr_en, 0);
  endtask

  task automatic t_binary;
    run(0, 7, 5, 0, 0, 12, 1, 0, 0, 0, "R2 add");
    run(0, 9, 8, 0, 0, 1, 1, 0, 1, 0, "R2 add carry");
    run(1, 3, 4, 0, 0, 8, 1, 0, 0, 0, "R2 addc");
    run(2, 3, 5, 0, 0, 14, 1, 0, 1, 0, "R2 sub borrow");
    run(3, 8, 2, 0, 0, 5, 1, 0, 0, 0, "R2 subc");
    run(1, 9, 9, 0, 0, 2, 1, 0, 1, 0, "R2 rotl c0");
    run(1, 9, 9, 0, 0, 3, 1, 0, 1, 0, "R2 rotl c1");
  endtask

  task automatic t_decimal;
    run(0, 5, 8, 1, 0, 3, 1, 0, 1, 0, "R3 dec add");
    run(0, 4, 5, 1, 0, 9, 1, 0, 0, 0, "R3 dec add nine");
    run(2, 3, 5, 1, 0, 8, 1, 0, 1, 0, "R3 dec sub");
    run(1, 2, 7, 1, 0, 0, 1, 0, 1, 1, "R3 dec addc wrap");
  endtask

  task automatic t_compare_chain;
    run(2, 5, 5, 0, 0, 0, 1, 0, 0, 1, "R5 zero sets");
    run(2, 4, 4, 0, 1, 0, 0, 0, 0, 1, "R5 cmp zero holds");
    run(2, 4, 3, 0, 1, 1, 0, 0, 0, 0, "R5 cmp nonzero clears");
    run(2, 2, 2, 0, 1, 0, 0, 0, 0, 0, "R5 cmp zero keeps clear");
    run(2, 2, 3, 0, 1, 15, 0, 0, 1, 0, "R4 cmp no write");
  endtask

  task automatic t_logic;
    run(4, 4'b1100, 4'b1010, 0, 0, 4'b1000, 1, 0, 1, 0, "R6 and");
    run(5, 4'b1100, 4'b1010, 0, 0, 4'b1110, 1, 0, 1, 0, "R6 or");
    run(6, 4'b1100, 4'b1010, 0, 0, 4'b0110, 1, 0, 1, 0, "R6 xor");
    run(4, 4'b1100, 4'b0011, 0, 0, 4'b0000, 1, 0, 1, 0, "R6 and zero keeps z");
  endtask

  task automatic t_bits;
    run(7, 4'b1011, 4'b1010, 0, 0, 0, 0, 1, 1, 0, "R7 ones hit");
    run(7, 4'b1011, 4'b0110, 0, 0, 0, 0, 0, 1, 0, "R7 ones miss");
    run(8, 4'b1011, 4'b0100, 0, 0, 0, 0, 1, 1, 0, "R7 zeros hit");
    run(8, 4'b1011, 4'b0011, 0, 0, 0, 0, 0, 1, 0, "R7 zeros miss");
  endtask

  task automatic t_compare;
    run(9, 6, 6, 0, 0, 0, 0, 1, 1, 0, "R8 eq");
    run(9, 6, 7, 0, 0, 0, 0, 0, 1, 0, "R8 eq miss");
    run(10, 6, 7, 0, 0, 0, 0, 1, 1, 0, "R8 ne");
    run(10, 6, 6, 0, 0, 0, 0, 0, 1, 0, "R8 ne miss");
    run(11, 7, 7, 0, 0, 0, 0, 1, 1, 0, "R8 ge equal");
    run(11, 3, 9, 0, 0, 0, 0, 0, 1, 0, "R8 ge below");
    run(11, 9, 3, 0, 0, 0, 0, 1, 1, 0, "R8 ge above");
    run(12, 3, 9, 0, 0, 0, 0, 1, 1, 0, "R8 lt");
    run(12, 9, 3, 0, 0, 0, 0, 0, 1, 0, "R8 lt miss");
  endtask

  task automatic t_rotate;
    run(13, 4'b0110, 0, 0, 0, 4'b1011, 1, 0, 0, 0, "R9 ror c1");
    run(13, 4'b0101, 0, 0, 0, 4'b0010, 1, 0, 1, 0, "R9 ror c0");
  endtask

  task automatic t_idle;
    @(negedge clk);
    opcode = 9; opa = 5; opb = 5; exec = 0;
    #1;
    chk("R10", "idle skip", skip, 0);
    chk("R10", "idle wr_en", wr_en, 0);
    @(negedge clk);
    opcode = 2; opa = 1; opb = 9;
    @(posedge clk); #1;
    chk("R10", "idle cy", cy, 1);
    chk("R10", "idle zf", zf, 0);
  endtask

  initial begin
    t_reset;
    #12 rst_n = 1;
    t_binary;
    t_decimal;
    t_compare_chain;
    t_logic;
    t_bits;
    t_compare;
    t_rotate;
    t_idle;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule